// File: doc/BRIEF.md
# Dark Column Black-Level Estimator

This block sits on the pixel stream of one horizontal readout channel of an interline CCD, after the converter. It tracks each pixel's column position within a line. From that position it sorts the pixel into one of six zones: leading shift-register dummies, the two outermost shielded columns, the trusted shielded columns, the light-sensitive buffer band, the active image, or trailing overclock.

The trusted shielded pixels of each line are summed. When the last of them is accepted, their mean is latched as the black level for that line. Every active pixel of the same line then leaves the block with that level subtracted, and a result below zero clamps to zero. All other pixels pass through unchanged, with the active flag low. A sideband flag on the line's first beat marks a line from the top or bottom shielded rows. The black level is held across such a line, because those rows are not reliably dark.

Both stream edges use valid/ready. An input beat transfers on a rising edge where `s_valid` and `s_ready` are both high. An output beat transfers where `m_valid` and `m_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. While `m_ready` is low with `m_valid` high, the output beat holds steady and no new input is taken.

Top module: `darkcol_black_est`

## Requirements
- R1: While reset is asserted, `m_valid` is 0, `dark_level` is 0 and `s_ready` is 1.
- R2: A beat with `s_sol` high is column 0, and each later accepted beat advances the column by one. Columns 0..DUMMY_N-1 (dummies), the shielded band of DARK_N columns, and the following BUF_N buffer columns are output unchanged with `m_active` = 0.
- R3: The black level is floor(sum/USE_N) over the shielded columns, excluding TRIM_N columns at each end of the band (USE_N = DARK_N - 2*TRIM_N). With the defaults these are columns 12..31, divided by 20. Dummy, outer shielded, buffer, active and overclock pixels never contribute.
- R4: `dark_level` changes only on the edge that accepts the last trusted shielded column. Active pixels of that line use the new value.
- R5: Active columns (ACTIVE_N of them, starting right after the buffer band) are output as max(pixel - dark_level, 0) with `m_active` = 1.
- R6: Columns at or beyond the end of the active range are output unchanged with `m_active` = 0.
- R7: If `s_hold_ref` is 1 on a line's `s_sol` beat, `dark_level` is not updated during that line, and its active pixels are corrected with the held level.
- R8: `s_ready` equals !`m_valid` || `m_ready`. While `m_valid` is 1 and `m_ready` is 0, `m_data` and `m_active` stay stable. Beats leave in acceptance order.
- R9: Beats accepted before the first `s_sol` after reset are treated as overclock. A line cut short before its last trusted shielded column leaves `dark_level` unchanged.
- R10: An accepted input beat is presented with `m_valid` = 1 in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input pixel beat valid |
| s_ready | output | 1 | Block can take an input beat |
| s_data | input | PIX_W | Digitised pixel value |
| s_sol | input | 1 | Beat is column 0 of a new line |
| s_hold_ref | input | 1 | Sampled on the `s_sol` beat: line must not update the black level |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream takes the output beat |
| m_data | output | PIX_W | Corrected (active) or passed-through pixel |
| m_active | output | 1 | Output beat is an active image pixel |
| dark_level | output | PIX_W | Latched black level of the current line |

## Verification
An output beat is due one cycle after its input is accepted. `dark_level` moves on the same edge that accepts the last trusted shielded column. The bench drives and samples at falling edges. It models each accepted beat at the falling edge before the accepting rising edge, and compares its queued expectation when that beat is handed off at a later falling edge. The model's black level is committed one falling edge after the last trusted column is accepted, so the check of `dark_level` lands exactly in the first cycle where the new value is visible. Random gaps in `s_valid` and random low periods on `m_ready` shift these due cycles. The model follows actual handshakes rather than a fixed schedule, so those shifts do not disturb the checks.

// File: rtl/dkl_pkg.sv
package dkl_pkg;
  typedef enum logic [2:0] {
    Z_DUMMY  = 3'd0,
    Z_EDGE   = 3'd1,
    Z_REF    = 3'd2,
    Z_BUFFER = 3'd3,
    Z_ACTIVE = 3'd4,
    Z_OVER   = 3'd5
  } zone_e;

  function automatic int trusted_cols(int dark_n, int trim_n);
    return dark_n - 2 * trim_n;
  endfunction
endpackage

// File: rtl/dkl_col_tracker.sv
module dkl_col_tracker
  import dkl_pkg::*;
#(
  parameter int CNT_W    = 13,
  parameter int DUMMY_N  = 11,
  parameter int DARK_N   = 22,
  parameter int TRIM_N   = 1,
  parameter int BUF_N    = 12,
  parameter int ACTIVE_N = 2448
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  beat,
  input  logic  sol,
  input  logic  hold_in,
  output zone_e zone,
  output logic  ref_first,
  output logic  ref_last,
  output logic  hold_cur
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] P_REF   = CNT_W'(DUMMY_N);
  localparam logic [CNT_W-1:0] P_UF    = CNT_W'(DUMMY_N + TRIM_N);
  localparam logic [CNT_W-1:0] P_UL    = CNT_W'(DUMMY_N + DARK_N - TRIM_N - 1);
  localparam logic [CNT_W-1:0] P_BUF   = CNT_W'(DUMMY_N + DARK_N);
  localparam logic [CNT_W-1:0] P_ACT   = CNT_W'(DUMMY_N + DARK_N + BUF_N);
  localparam logic [CNT_W-1:0] P_END   = CNT_W'(DUMMY_N + DARK_N + BUF_N + ACTIVE_N);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic             hold_q;

  always_comb idx = sol ? '0 : cnt_q;

  always_comb begin
    if (idx < P_REF)       zone = Z_DUMMY;
    else if (idx < P_BUF)  zone = (idx < P_UF || idx > P_UL) ? Z_EDGE : Z_REF;
    else if (idx < P_ACT)  zone = Z_BUFFER;
    else if (idx < P_END)  zone = Z_ACTIVE;
    else                   zone = Z_OVER;
  end

  always_comb begin
    ref_first = (idx == P_UF);
    ref_last  = (idx == P_UL);
    hold_cur  = sol ? hold_in : hold_q;
  end

  // Counter parks at its maximum (overclock) until the first line start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_MAX;
      hold_q <= 1'b0;
    end else if (beat) begin
      cnt_q <= (idx == CNT_MAX) ? idx : idx + 1'b1;
      if (sol) hold_q <= hold_in;
    end
  end

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat && sol |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/dkl_dark_accum.sv
module dkl_dark_accum
  import dkl_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int USE_N = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  zone_e            zone,
  input  logic             ref_first,
  input  logic             ref_last,
  input  logic             hold,
  input  logic [PIX_W-1:0] pix,
  output logic [PIX_W-1:0] dark_q
);
  localparam int  LOG_N = $clog2(USE_N);
  localparam int  SUM_W = PIX_W + LOG_N;
  localparam bit  POW2  = ((USE_N & (USE_N - 1)) == 0);

  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] sum_next;
  logic [PIX_W-1:0] avg;

  always_comb sum_next = (ref_first ? '0 : acc_q) + SUM_W'(pix);

  generate
    if (POW2) begin : g_shift
      assign avg = PIX_W'(sum_next >> LOG_N);
    end else begin : g_recip
      // Rounded-up reciprocal; SHIFT wide enough that floor(sum*RECIP>>SHIFT) is exact.
      localparam int SHIFT  = SUM_W + LOG_N;
      localparam int PROD_W = SUM_W + SHIFT + 1;
      localparam logic [PROD_W-1:0] RECIP =
        PROD_W'(((64'd1 << SHIFT) + 64'(USE_N) - 64'd1) / 64'(USE_N));
      assign avg = PIX_W'((PROD_W'(sum_next) * RECIP) >> SHIFT);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      dark_q <= '0;
    end else if (beat && zone == Z_REF) begin
      acc_q <= sum_next;
      if (ref_last && !hold) dark_q <= avg;
    end
  end

  assert_dark_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dark_q) |-> $past(beat && zone == Z_REF && ref_last && !hold));
endmodule

// File: rtl/dkl_corrector.sv
module dkl_corrector
  import dkl_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PIX_W-1:0] pix,
  input  zone_e            zone,
  input  logic [PIX_W-1:0] dark,
  input  logic             m_ready,
  output logic             m_valid,
  output logic [PIX_W-1:0] m_data,
  output logic             m_active,
  output logic             beat
);
  logic             is_act;
  logic [PIX_W-1:0] corr;

  always_comb begin
    s_ready = !m_valid || m_ready;
    beat    = s_valid && s_ready;
    is_act  = (zone == Z_ACTIVE);
    corr    = (pix > dark) ? (pix - dark) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_data   <= '0;
      m_active <= 1'b0;
    end else if (beat) begin
      m_valid  <= 1'b1;
      m_data   <= is_act ? corr : pix;
      m_active <= is_act;
    end else if (m_ready) begin
      m_valid  <= 1'b0;
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_active));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> m_valid);

  assert_clamp_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> m_data <= $past(pix));

  assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat && zone != Z_ACTIVE |=> !m_active && m_data == $past(pix));
endmodule

// File: rtl/darkcol_black_est.sv
module darkcol_black_est
  import dkl_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int DUMMY_N  = 11,
  parameter int DARK_N   = 22,
  parameter int TRIM_N   = 1,
  parameter int BUF_N    = 12,
  parameter int ACTIVE_N = 2448,
  parameter int CNT_W    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PIX_W-1:0] s_data,
  input  logic             s_sol,
  input  logic             s_hold_ref,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PIX_W-1:0] m_data,
  output logic             m_active,
  output logic [PIX_W-1:0] dark_level
);
  localparam int USE_N = trusted_cols(DARK_N, TRIM_N);

  zone_e zone;
  logic  ref_first;
  logic  ref_last;
  logic  hold_cur;
  logic  beat;

  dkl_col_tracker #(
    .CNT_W(CNT_W), .DUMMY_N(DUMMY_N), .DARK_N(DARK_N),
    .TRIM_N(TRIM_N), .BUF_N(BUF_N), .ACTIVE_N(ACTIVE_N)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sol(s_sol), .hold_in(s_hold_ref),
    .zone(zone), .ref_first(ref_first), .ref_last(ref_last), .hold_cur(hold_cur)
  );

  dkl_dark_accum #(.PIX_W(PIX_W), .USE_N(USE_N)) u_accum (
    .clk(clk), .rst_n(rst_n), .beat(beat), .zone(zone),
    .ref_first(ref_first), .ref_last(ref_last), .hold(hold_cur),
    .pix(s_data), .dark_q(dark_level)
  );

  dkl_corrector #(.PIX_W(PIX_W)) u_corr (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .pix(s_data), .zone(zone), .dark(dark_level), .m_ready(m_ready),
    .m_valid(m_valid), .m_data(m_data), .m_active(m_active), .beat(beat)
  );
endmodule

// File: tb/darkcol_black_est_tb.sv
module darkcol_black_est_tb;
  localparam int ACT   = 24;
  localparam int UF    = 12;
  localparam int UL    = 31;
  localparam int ASTART = 45;
  localparam int AEND  = ASTART + ACT;
  localparam int QN    = 8192;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_ready, s_sol = 1'b0, s_hold_ref = 1'b0;
  logic [11:0] s_data = '0;
  logic m_valid, m_ready = 1'b0, m_active;
  logic [11:0] m_data, dark_level;

  always #4ns clk = ~clk;

  darkcol_black_est #(
    .PIX_W(12), .DUMMY_N(11), .DARK_N(22), .TRIM_N(1), .BUF_N(12),
    .ACTIVE_N(ACT), .CNT_W(8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sol(s_sol), .s_hold_ref(s_hold_ref),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_active(m_active), .dark_level(dark_level)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit wd = 1'b0;
  int exp_d [QN];
  bit exp_a [QN];
  int exp_t [QN];
  int head = 0, tail = 0;
  int m_idx = -1, m_acc = 0, m_dark = 0, m_pend = 0;
  bit m_hold = 1'b0;
  int vpct = 100, rpct = 100;
  bit stall_prev = 1'b0, acc_prev = 1'b0, stall_a = 1'b0;
  logic [11:0] stall_d = '0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic string tag_name(input int c);
    case (c)
      2: return "R2";
      5: return "R5";
      6: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic model_push(input logic [11:0] d, input bit sol, input bit hold);
    int e; bit a; int t;
    if (sol) begin m_idx = 0; m_hold = hold; end
    else if (m_idx >= 0) m_idx++;
    if (m_idx < 0) begin e = d; a = 0; t = 9; end
    else if (m_idx >= AEND) begin e = d; a = 0; t = 6; end
    else if (m_idx >= ASTART) begin
      e = (d > m_dark) ? d - m_dark : 0; a = 1; t = 5;
    end else begin
      e = d; a = 0; t = 2;
      if (m_idx >= UF && m_idx <= UL) begin
        m_acc = (m_idx == UF) ? int'(d) : m_acc + int'(d);
        if (m_idx == UL && !m_hold) m_pend = m_acc / 20;
      end
    end
    exp_d[tail] = e; exp_a[tail] = a; exp_t[tail] = t;
    tail = (tail + 1) % QN;
  endtask

  task automatic step(input bit v, input logic [11:0] d, input bit sol, input bit hold,
                      output bit took);
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT && !wd) begin
      wd = 1'b1;
      chk(1'b0, "watchdog", cyc, WD_LIMIT);
    end
    s_valid = v; s_data = d; s_sol = sol; s_hold_ref = hold;
    m_ready = (($urandom % 100) < rpct);
    #1ns;
    m_dark = m_pend;
    // R3/R4/R7/R9: black level visible from the edge after its last trusted column
    chk(dark_level == 12'(m_dark), "R3/R4/R7/R9 dark_level", dark_level, m_dark);
    if (stall_prev)
      chk(m_valid && m_data == stall_d && m_active == stall_a, "R8 stall hold",
          m_data, stall_d);
    if (acc_prev) chk(m_valid, "R10 latency", m_valid, 1);
    chk(s_ready == (!m_valid || m_ready), "R8 ready rule", s_ready, !m_valid || m_ready);
    if (m_valid && m_ready) begin
      if (head == tail) chk(1'b0, "R8 unexpected beat", m_data, -1);
      else begin
        chk(m_data == 12'(exp_d[head]) && m_active == exp_a[head],
            tag_name(exp_t[head]), m_data + 4096 * m_active,
            exp_d[head] + 4096 * exp_a[head]);
        head = (head + 1) % QN;
      end
    end
    stall_prev = m_valid && !m_ready;
    stall_d = m_data; stall_a = m_active;
    took = v && s_ready;
    acc_prev = took;
    if (took) model_push(d, sol, hold);
  endtask

  task automatic send_pixel(input logic [11:0] d, input bit sol, input bit hold);
    bit took = 1'b0;
    while (!took && !wd) begin
      if (($urandom % 100) < vpct) step(1'b1, d, sol, hold, took);
      else step(1'b0, 12'($urandom), 1'($urandom), 1'b0, took);
    end
  endtask

  // mode 0: normal shielded values; mode 1: shielded columns all at full scale
  task automatic send_line(input int len, input bit hold, input int mode);
    for (int i = 0; i < len && !wd; i++) begin
      logic [11:0] d;
      if (i >= UF && i <= UL)
        d = (mode == 1) ? 12'hFFF : 12'(100 + $urandom % 301);
      else if (i >= ASTART && i < AEND)
        d = ($urandom % 2 == 1) ? 12'($urandom) : 12'(150 + $urandom % 201);
      else
        d = 12'hFFF - 12'($urandom % 16);
      send_pixel(d, i == 0, hold);
    end
  endtask

  initial begin
    bit took;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(m_valid == 1'b0, "R1 m_valid", m_valid, 0);
    chk(dark_level == 12'd0, "R1 dark_level", dark_level, 0);
    chk(s_ready == 1'b1, "R1 s_ready", s_ready, 1);
    rst_n = 1'b1;
    // R9: beats before any line start pass as overclock
    for (int k = 0; k < 3; k++) send_pixel(12'(3000 + k), 1'b0, 1'b0);
    send_line(AEND + 5, 1'b0, 0);          // R2 R3 R5 R6 full line
    send_line(AEND + 3, 1'b1, 0);          // R7 held reference line
    vpct = 60; rpct = 50;
    send_line(25, 1'b0, 1);                // R9 short line, no update
    send_line(AEND + 2, 1'b0, 1);          // R5 full-scale black: all clamp to 0
    send_line(AEND, 1'b0, 0);
    for (int n = 0; n < 24 && !wd; n++) begin
      vpct = 50 + $urandom % 51;
      rpct = 40 + $urandom % 61;
      send_line(40 + $urandom % 50, ($urandom % 6) == 0, ($urandom % 8) == 0 ? 1 : 0);
    end
    rpct = 100;
    while ((head != tail || m_valid) && !wd) step(1'b0, 12'd0, 1'b0, 1'b0, took);
    chk(head == tail, "R8 all beats delivered", tail - head, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule